// File: doc/BRIEF.md
# Two-Level Sample Pacing Generator

This block produces the conversion strobes for a multi-channel sampler. A slow scan counter decides when a scan begins. A fast conversion counter then spaces out the individual conversions inside that scan. Both counters advance only on cycles where the timebase tick enable is high, which is nominally an 8 MHz rate (125 ns). Each counter has a reload value R and a period of R+1 ticks. The smallest legal divider is 2, so the smallest legal reload is 1. Either trigger, scan start or conversion, can come from its internal counter or from an external pin. An external pin passes through a two-stage synchroniser and a rising-edge detector before the block uses it.

In single-channel mode every scan event is itself one conversion. In burst mode a scan event opens a burst of `burst_len_m1`+1 conversions. A scan event that arrives while a burst is still open is dropped and raises a sticky overrun flag. A separate sample-block counter is loaded with N-1. It counts stored-sample pulses and emits a block-complete pulse after every N of them. When enabled, that pulse can also halt pacing. Stopping reloads every counter, so the first period after a restart is always a full one.

Top module: `pacer_timing_gen`

## Requirements
- R1: After reset `conv_strobe`, `block_done`, `scan_overrun` and `running` are all 0.
- R2: A `sw_start` pulse sets `running` and a `sw_stop` pulse clears it. When both are high in the same cycle, stop wins. No strobe or block pulse appears in the cycle after one in which `running` is 0.
- R3: In single-channel mode (`multi_chan`=0) with the internal scan source (`scan_src_ext`=0), the first `conv_strobe` comes `scan_reload`+1 ticks after the start. Later strobes follow every `scan_reload`+1 ticks. Each strobe is one cycle wide.
- R4: Counters move only in cycles with `tick_en`=1. While `tick_en` is held at 0, no internally paced strobe occurs.
- R5: In burst mode (`multi_chan`=1), a scan event opens a burst of exactly `burst_len_m1`+1 conversions. With the internal conversion source (`conv_src_ext`=0), the first conversion comes `conv_reload`+1 ticks after the scan event. The remaining conversions are spaced `conv_reload`+1 ticks apart.
- R6: A scan event while a burst is open is ignored and sets `scan_overrun`. This includes a scan event in the same cycle as the burst's last conversion. The flag stays set until the next `sw_start`. A scan event in the cycle after the last conversion opens a new burst without an overrun.
- R7: With an external source selected (`scan_src_ext`=1 or `conv_src_ext`=1), the strobe appears 3 clock cycles after the cycle in which the pin first goes high. A held level gives only one strobe. External scan edges are ignored while stopped. External conversion edges are ignored outside a burst. Internal counters of a source set to external have no effect.
- R8: While running, `block_done` pulses for one cycle after every `block_reload`+1 `sample_wr` pulses. The pulse appears in the cycle after the final `sample_wr`. `sample_wr` pulses while stopped are not counted.
- R9: With `stop_on_block`=1, the block-complete pulse also clears `running` at the same edge.
- R10: A stop reloads the scan, conversion, burst and block counters. A start that follows a partial period therefore yields a full first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick enable |
| sw_start | input | 1 | Start pulse |
| sw_stop | input | 1 | Stop pulse |
| multi_chan | input | 1 | 1 = burst mode, 0 = single-channel |
| scan_src_ext | input | 1 | 1 = scan events from `ext_scan_trig` |
| conv_src_ext | input | 1 | 1 = conversions from `ext_conv_trig` |
| stop_on_block | input | 1 | Block-complete halts pacing |
| scan_reload | input | 24 | Scan period minus one, in ticks |
| conv_reload | input | 10 | Conversion spacing minus one, in ticks |
| burst_len_m1 | input | 7 | Conversions per burst minus one |
| block_reload | input | 16 | Samples per block minus one |
| ext_scan_trig | input | 1 | Asynchronous external scan trigger |
| ext_conv_trig | input | 1 | Asynchronous external conversion trigger |
| sample_wr | input | 1 | One pulse per stored sample |
| running | output | 1 | Pacing active |
| conv_strobe | output | 1 | One-cycle conversion strobe |
| block_done | output | 1 | One-cycle block-complete pulse |
| scan_overrun | output | 1 | Sticky scan overrun flag |

## Verification
The sharpest collision in this block is a new scan tick landing in the same cycle as the last conversion of the current burst. The bench provokes it by choosing (`burst_len_m1`+1)·(`conv_reload`+1) equal to `scan_reload`+1. It then requires the overrun flag, the four conversions of the first burst and no strobes from the dropped scan. Shortening the burst by one cycle, so that the product equals `scan_reload`, must instead reopen a burst cleanly with the flag clear. A second collision is the block-complete pulse coinciding with a halt: with `stop_on_block` set, the pulse and the drop of `running` must appear together.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic {SRC_INTERNAL = 1'b0, SRC_EXTERNAL = 1'b1} trig_src_e;
  localparam int NUM_EXT      = 2;
  localparam int EXT_SCAN_IDX = 0;
  localparam int EXT_CONV_IDX = 1;
endpackage

// File: rtl/pacer_edge_sync.sv
module pacer_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], async_in};
  end

  assign rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/pacer_reload_ctr.sv
module pacer_reload_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= reload;
    else if (step) cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end
endmodule

// File: rtl/pacer_timing_gen.sv
module pacer_timing_gen
  import pacer_pkg::*;
#(
  parameter int SCAN_W = 24,
  parameter int CONV_W = 10,
  parameter int LEN_W  = 7,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              multi_chan,
  input  logic              scan_src_ext,
  input  logic              conv_src_ext,
  input  logic              stop_on_block,
  input  logic [SCAN_W-1:0] scan_reload,
  input  logic [CONV_W-1:0] conv_reload,
  input  logic [LEN_W-1:0]  burst_len_m1,
  input  logic [BLK_W-1:0]  block_reload,
  input  logic              ext_scan_trig,
  input  logic              ext_conv_trig,
  input  logic              sample_wr,
  output logic              running,
  output logic              conv_strobe,
  output logic              block_done,
  output logic              scan_overrun
);
  logic [NUM_EXT-1:0] ext_raw, ext_rise;
  trig_src_e scan_src, conv_src;
  logic run_q, burst_q, ovr_q, strobe_q, blk_q;
  logic scan_hit, conv_hit, last_conv, blk_evt;
  logic scan_evt, burst_conv_evt, conv_evt;
  logic stop_req, burst_open, scan_clash;

  assign ext_raw[EXT_SCAN_IDX] = ext_scan_trig;
  assign ext_raw[EXT_CONV_IDX] = ext_conv_trig;
  assign scan_src = trig_src_e'(scan_src_ext);
  assign conv_src = trig_src_e'(conv_src_ext);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    pacer_edge_sync u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_raw[i]), .rise(ext_rise[i])
    );
  end

  pacer_reload_ctr #(.W(SCAN_W)) u_scan_ctr (
    .clk(clk), .rst_n(rst_n), .load(!run_q), .step(run_q & tick_en),
    .reload(scan_reload), .hit(scan_hit)
  );

  pacer_reload_ctr #(.W(CONV_W)) u_conv_ctr (
    .clk(clk), .rst_n(rst_n), .load(!burst_q), .step(burst_q & tick_en),
    .reload(conv_reload), .hit(conv_hit)
  );

  pacer_reload_ctr #(.W(LEN_W)) u_len_ctr (
    .clk(clk), .rst_n(rst_n), .load(!burst_q), .step(burst_conv_evt),
    .reload(burst_len_m1), .hit(last_conv)
  );

  pacer_reload_ctr #(.W(BLK_W)) u_blk_ctr (
    .clk(clk), .rst_n(rst_n), .load(!run_q), .step(run_q & sample_wr),
    .reload(block_reload), .hit(blk_evt)
  );

  always_comb begin
    scan_evt       = run_q & ((scan_src == SRC_EXTERNAL) ? ext_rise[EXT_SCAN_IDX] : scan_hit);
    burst_conv_evt = burst_q & ((conv_src == SRC_EXTERNAL) ? ext_rise[EXT_CONV_IDX] : conv_hit);
    conv_evt       = multi_chan ? burst_conv_evt : scan_evt;
    burst_open     = multi_chan & scan_evt & ~burst_q;
    scan_clash     = multi_chan & scan_evt & burst_q;
    stop_req       = sw_stop | (stop_on_block & blk_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      burst_q  <= 1'b0;
      ovr_q    <= 1'b0;
      strobe_q <= 1'b0;
      blk_q    <= 1'b0;
    end else begin
      strobe_q <= conv_evt;
      blk_q    <= blk_evt;
      if (stop_req)      run_q <= 1'b0;
      else if (sw_start) run_q <= 1'b1;
      if (!run_q || stop_req) burst_q <= 1'b0;
      else if (burst_open)    burst_q <= 1'b1;
      else if (last_conv)     burst_q <= 1'b0;
      if (sw_start)        ovr_q <= 1'b0;
      else if (scan_clash) ovr_q <= 1'b1;
    end
  end

  assign running      = run_q;
  assign conv_strobe  = strobe_q;
  assign block_done   = blk_q;
  assign scan_overrun = ovr_q;
endmodule

// File: rtl/pacer_timing_chk.sv
module pacer_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_start,
  input logic stop_on_block,
  input logic running,
  input logic conv_strobe,
  input logic block_done,
  input logic scan_overrun
);
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !conv_strobe); // R2

  AST_IDLE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !block_done); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_overrun && !sw_start) |=> scan_overrun); // R6

  AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> !scan_overrun); // R6

  AST_BLOCK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && $past(stop_on_block)) |-> !running); // R9
endmodule

bind pacer_timing_gen pacer_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .stop_on_block(stop_on_block),
  .running(running), .conv_strobe(conv_strobe), .block_done(block_done),
  .scan_overrun(scan_overrun)
);

// File: tb/pacer_timing_gen_test.sv
module pacer_timing_gen_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b1, sw_start = 1'b0, sw_stop = 1'b0;
  logic multi_chan = 1'b0, scan_src_ext = 1'b0, conv_src_ext = 1'b0, stop_on_block = 1'b0;
  logic [23:0] scan_reload = 24'd4;
  logic [9:0]  conv_reload = 10'd2;
  logic [6:0]  burst_len_m1 = 7'd0;
  logic [15:0] block_reload = 16'd0;
  logic ext_scan_trig = 1'b0, ext_conv_trig = 1'b0, sample_wr = 1'b0;
  logic running, conv_strobe, block_done, scan_overrun;

  pacer_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sw_start(sw_start), .sw_stop(sw_stop),
    .multi_chan(multi_chan), .scan_src_ext(scan_src_ext), .conv_src_ext(conv_src_ext),
    .stop_on_block(stop_on_block), .scan_reload(scan_reload), .conv_reload(conv_reload),
    .burst_len_m1(burst_len_m1), .block_reload(block_reload),
    .ext_scan_trig(ext_scan_trig), .ext_conv_trig(ext_conv_trig), .sample_wr(sample_wr),
    .running(running), .conv_strobe(conv_strobe), .block_done(block_done),
    .scan_overrun(scan_overrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, c0 = 0, me = 0;
  bit finished = 1'b0;
  string cur_tag = "R1", mt;
  int conv_q[$]; string conv_t[$];
  int blk_q[$];  string blk_t[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every produced pulse must match the head of its queue
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (conv_strobe) begin
        if (conv_q.size() == 0) chk(1'b0, cur_tag, cyc, -1);
        else begin
          me = conv_q.pop_front(); mt = conv_t.pop_front();
          chk(cyc == me, mt, cyc, me);
        end
      end
      if (block_done) begin
        if (blk_q.size() == 0) chk(1'b0, cur_tag, cyc, -1);
        else begin
          me = blk_q.pop_front(); mt = blk_t.pop_front();
          chk(cyc == me, mt, cyc, me);
        end
      end
    end
  end

  task automatic push_conv(int t, string tag); conv_q.push_back(t); conv_t.push_back(tag); endtask
  task automatic push_blk(int t, string tag);  blk_q.push_back(t);  blk_t.push_back(tag);  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic start_run();
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0; c0 = cyc;
  endtask

  task automatic stop_run();
    sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (6) @(negedge clk);
    chk(conv_q.size() == 0, tag, conv_q.size(), 0);
    chk(blk_q.size() == 0, tag, blk_q.size(), 0);
    conv_q.delete(); conv_t.delete(); blk_q.delete(); blk_t.delete();
  endtask

  task automatic cfg(bit m, bit se, bit ce, int r, int c, int l);
    multi_chan = m; scan_src_ext = se; conv_src_ext = ce;
    scan_reload = 24'(r); conv_reload = 10'(c); burst_len_m1 = 7'(l);
  endtask

  task automatic pulse_ext(bit conv);
    if (conv) ext_conv_trig = 1'b1; else ext_scan_trig = 1'b1;
    repeat (3) @(negedge clk);
    ext_conv_trig = 1'b0; ext_scan_trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample_pulse();
    sample_wr = 1'b1; @(negedge clk); sample_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(conv_strobe == 1'b0, "R1", conv_strobe, 0);
    chk(block_done == 1'b0, "R1", block_done, 0);
    chk(scan_overrun == 1'b0, "R1", scan_overrun, 0);
    chk(running == 1'b0, "R1", running, 0);

    // R3 single-channel internal pacing, R2 stop
    cur_tag = "R3"; cfg(0, 0, 0, 4, 2, 0);
    start_run();
    chk(running == 1'b1, "R2", running, 1);
    for (int k = 1; k <= 3; k++) push_conv(c0 + 5 * k, "R3");
    wait_until(c0 + 17); stop_run();
    chk(running == 1'b0, "R2", running, 0);
    drain("R3");

    // R2 start and stop together: stop wins
    cur_tag = "R2";
    sw_start = 1'b1; sw_stop = 1'b1; @(negedge clk); sw_start = 1'b0; sw_stop = 1'b0;
    chk(running == 1'b0, "R2", running, 0);
    drain("R2");

    // R4 tick enable gating
    cur_tag = "R4"; tick_en = 1'b0;
    start_run();
    repeat (20) @(negedge clk);
    tick_en = 1'b1; push_conv(cyc + 5, "R4");
    wait_until(cyc + 7); stop_run();
    drain("R4");

    // R10 restart after partial period gives a full first period
    cur_tag = "R10";
    start_run(); push_conv(c0 + 5, "R10");
    wait_until(c0 + 7); stop_run();
    start_run(); push_conv(c0 + 5, "R10"); push_conv(c0 + 10, "R10");
    wait_until(c0 + 12); stop_run();
    drain("R10");

    // R5 burst mode, internal conversion clock
    cur_tag = "R5"; cfg(1, 0, 0, 19, 2, 3);
    start_run();
    for (int j = 1; j <= 4; j++) push_conv(c0 + 20 + 3 * j, "R5");
    for (int j = 1; j <= 4; j++) push_conv(c0 + 40 + 3 * j, "R5");
    wait_until(c0 + 55); stop_run();
    chk(scan_overrun == 1'b0, "R6", scan_overrun, 0);
    drain("R5");

    // R6 scan tick coinciding with last conversion -> overrun, dropped scan
    cur_tag = "R6"; cfg(1, 0, 0, 11, 2, 3);
    start_run();
    for (int j = 1; j <= 4; j++) push_conv(c0 + 12 + 3 * j, "R6");
    wait_until(c0 + 30); stop_run();
    chk(scan_overrun == 1'b1, "R6", scan_overrun, 1);
    repeat (3) @(negedge clk);
    chk(scan_overrun == 1'b1, "R6", scan_overrun, 1);
    drain("R6");
    // one cycle of slack: new burst opens without overrun
    cfg(1, 0, 0, 12, 2, 3);
    start_run();
    chk(scan_overrun == 1'b0, "R6", scan_overrun, 0);
    for (int j = 1; j <= 4; j++) push_conv(c0 + 13 + 3 * j, "R6");
    wait_until(c0 + 27); stop_run();
    chk(scan_overrun == 1'b0, "R6", scan_overrun, 0);
    drain("R6");

    // R7 external scan trigger, single-channel
    cur_tag = "R7"; cfg(0, 1, 0, 5, 2, 0);
    pulse_ext(1'b0);                        // stopped: ignored
    start_run();
    repeat (3) @(negedge clk);
    push_conv(cyc + 3, "R7"); pulse_ext(1'b0);
    push_conv(cyc + 3, "R7"); pulse_ext(1'b0);
    repeat (3) @(negedge clk); stop_run();
    drain("R7");

    // R7 external conversion trigger inside a burst
    cfg(1, 0, 1, 40, 2, 1);
    start_run();
    wait_until(c0 + 10); pulse_ext(1'b1);   // no burst open: ignored
    wait_until(c0 + 45); push_conv(cyc + 3, "R7"); pulse_ext(1'b1);
    wait_until(c0 + 50); push_conv(cyc + 3, "R7"); pulse_ext(1'b1);
    wait_until(c0 + 56); pulse_ext(1'b1);   // burst closed: ignored
    wait_until(c0 + 70); stop_run();
    drain("R7");

    // R8 block counter, N = 3
    cur_tag = "R8"; cfg(0, 0, 0, 60000, 2, 0); block_reload = 16'd2;
    sample_pulse(); sample_pulse();        // stopped: not counted
    start_run();
    for (int k = 1; k <= 7; k++) begin
      if (k % 3 == 0) push_blk(cyc + 1, "R8");
      sample_pulse();
    end
    stop_run();
    drain("R8");

    // R9 block-complete halts pacing
    cur_tag = "R9"; block_reload = 16'd1; stop_on_block = 1'b1;
    start_run();
    sample_pulse();
    chk(running == 1'b1, "R9", running, 1);
    push_blk(cyc + 1, "R9");
    sample_wr = 1'b1; @(negedge clk); sample_wr = 1'b0;
    chk(running == 1'b0, "R9", running, 0);
    stop_on_block = 1'b0;
    drain("R9");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule